// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Controller

This block turns one PWM command into two gate-enable outputs for the upper and lower switches of a synchronous buck stage, and keeps them from ever being on together. Dead time is not a fixed count. When the upper switch turns off, the lower one turns on as soon as a switch-node comparator shows the node has dropped below its low threshold. If the node never rose during the upper on-phase, a short fixed delay is used instead. If the node never drops, a longer timeout turns the lower switch on anyway. When the lower switch turns off, the upper one waits for a comparator showing the lower gate has discharged, then waits a short fixed hold time.

The PWM command, the active-low disable and both comparator flags enter through two-flop synchronizers. An internal reset synchronizer releases reset cleanly. Every delay is a parameter in clock cycles. The defaults are 12, 24 and 4 cycles.

Top module: `buck_deadtime_ctrl`

## Requirements
- R1: With drv_en high and pwm_cmd held long enough, hs_on follows pwm_cmd and ls_on is its inverse (pwm_cmd=1 gives hs_on=1, ls_on=0; pwm_cmd=0 gives hs_on=0, ls_on=1).
- R2: While drv_en is low, both outputs are low no later than the third rising clock edge after drv_en falls, and they stay low whatever pwm_cmd does.
- R3: hs_on and ls_on are never high in the same cycle.
- R4: After an upper on-phase in which sw_low was seen low, ls_on rises on the third rising edge after sw_low goes high, provided this comes before the timeout.
- R5: After an upper on-phase in which sw_low stayed high throughout, ls_on rises exactly T_FIX cycles after hs_on falls.
- R6: If the node went high and sw_low never returns high, ls_on rises exactly T_TMO cycles after hs_on falls.
- R7: After ls_on falls, hs_on rises exactly T_HOLD cycles after the first cycle in which the synchronized lgate_low is seen high. In port terms, that is T_HOLD+3 cycles after lgate_low rises.
- R8: If pwm_cmd rises again while the lower turn-on is still pending, ls_on never asserts. The controller goes straight to the upper turn-on sequence with both outputs low.
- R9: Reset drives both outputs low. A change on pwm_cmd first affects the outputs at the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwm_cmd | input | 1 | PWM command, asynchronous |
| drv_en | input | 1 | Active-low output disable: 0 forces both gates off |
| sw_low | input | 1 | Comparator: switch node below its low threshold |
| lgate_low | input | 1 | Comparator: lower gate below its discharge threshold |
| hs_on | output | 1 | Upper switch gate enable |
| ls_on | output | 1 | Lower switch gate enable |

## Verification
The assertions take the comparator flags at face value. They assume that lgate_low is low whenever the lower gate is on, and that a reversal of pwm_cmd is held long enough to pass through the synchronizers. Nothing is assumed about when sw_low moves, which is why the timeout bound is checked with a counter. The bench drives both comparators from small behavioural models of the power stage. These models tie the gate flag to ls_on and the node flag to hs_on with chosen lags. Every PWM phase is held far longer than the longest wait, so no flag is stale when its sequence begins.

// File: rtl/dt_pkg.sv
package dt_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_HS      = 3'd1,
    ST_WAIT_LS = 3'd2,
    ST_LS      = 3'd3,
    ST_WAIT_HS = 3'd4
  } dt_state_e;
endpackage

// File: rtl/dt_sync.sv
module dt_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dt_wait_cnt.sv
module dt_wait_cnt #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/buck_deadtime_ctrl.sv
module buck_deadtime_ctrl
  import dt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int T_FIX       = 12,
  parameter int T_TMO       = 24,
  parameter int T_HOLD      = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_cmd,
  input  logic drv_en,
  input  logic sw_low,
  input  logic lgate_low,
  output logic hs_on,
  output logic ls_on
);
  localparam int CW = $clog2(T_TMO + 1);
  localparam logic [CW-1:0] FIX_LAST  = CW'(T_FIX - 1);
  localparam logic [CW-1:0] TMO_LAST  = CW'(T_TMO - 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(T_HOLD - 1);

  logic rst_i_n;
  logic pwm_s, en_s, sw_s, lg_s;
  logic [3:0] sync_q;

  dt_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_i_n)
  );

  dt_sync #(.W(4), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk(clk), .rst_n(rst_i_n),
    .d({pwm_cmd, drv_en, sw_low, lgate_low}), .q(sync_q)
  );
  assign {pwm_s, en_s, sw_s, lg_s} = sync_q;

  dt_state_e st_q, st_d;
  logic armed_q, armed_d;
  logic node_hi_q, node_hi_d;
  logic cnt_clr, cnt_inc;
  logic [CW-1:0] cnt;
  logic go_ls;

  dt_wait_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
  );

  // Lower turn-on: node feedback, fixed delay when node never rose, or timeout
  assign go_ls = (node_hi_q && sw_s) || (!node_hi_q && cnt == FIX_LAST) ||
                 (cnt == TMO_LAST);

  always_comb begin
    st_d      = st_q;
    armed_d   = armed_q;
    node_hi_d = node_hi_q;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    if (!en_s) begin
      st_d      = ST_OFF;
      cnt_clr   = 1'b1;
      armed_d   = 1'b0;
      node_hi_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          cnt_clr   = 1'b1;
          armed_d   = 1'b0;
          node_hi_d = 1'b0;
          st_d      = pwm_s ? ST_WAIT_HS : ST_WAIT_LS;
        end
        ST_HS: begin
          if (!sw_s) node_hi_d = 1'b1;
          if (!pwm_s) begin
            st_d    = ST_WAIT_LS;
            cnt_clr = 1'b1;
          end
        end
        ST_WAIT_LS: begin
          if (pwm_s) begin
            st_d    = ST_WAIT_HS;
            cnt_clr = 1'b1;
            armed_d = 1'b0;
          end else if (go_ls) begin
            st_d    = ST_LS;
            cnt_clr = 1'b1;
          end else begin
            cnt_inc = 1'b1;
          end
        end
        ST_LS: begin
          if (pwm_s) begin
            st_d    = ST_WAIT_HS;
            cnt_clr = 1'b1;
            armed_d = 1'b0;
          end
        end
        ST_WAIT_HS: begin
          if (!pwm_s) begin
            st_d    = ST_WAIT_LS;
            cnt_clr = 1'b1;
          end else if (armed_q && cnt == HOLD_LAST) begin
            st_d      = ST_HS;
            cnt_clr   = 1'b1;
            node_hi_d = 1'b0;
          end else begin
            if (lg_s)    armed_d = 1'b1;
            if (armed_q) cnt_inc = 1'b1;
          end
        end
        default: begin
          st_d    = ST_OFF;
          cnt_clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q      <= ST_OFF;
      armed_q   <= 1'b0;
      node_hi_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      armed_q   <= armed_d;
      node_hi_q <= node_hi_d;
    end
  end

  assign hs_on = (st_q == ST_HS);
  assign ls_on = (st_q == ST_LS);
endmodule

// File: rtl/dt_check.sv
module dt_check #(
  parameter int T_TMO = 24
) (
  input logic clk,
  input logic rst_n,
  input logic hs,
  input logic ls,
  input logic pwm_s,
  input logic en_s
);
  localparam int LIM = T_TMO + 2;
  localparam int LW  = $clog2(LIM + 1);
  localparam logic [LW-1:0] BOUND = LW'(T_TMO + 1);
  localparam logic [LW-1:0] SAT   = LW'(LIM);

  logic [LW-1:0] lswait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lswait <= '0;
    else if (!hs && !ls && !pwm_s && en_s) begin
      if (lswait != SAT) lswait <= lswait + 1'b1;
    end else lswait <= '0;
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs && ls));
  assert_disable_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (!hs && !ls));
  assert_ls_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls) |-> $past(!hs));
  assert_hs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs) |-> $past(!ls));
  assert_ls_timeout_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lswait <= BOUND);
  assert_ls_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && pwm_s && ls) |=> !ls);
  assert_hs_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s && !pwm_s && hs) |=> !hs);
endmodule

bind buck_deadtime_ctrl dt_check #(.T_TMO(T_TMO)) u_dt_check (
  .clk(clk), .rst_n(rst_n), .hs(hs_on), .ls(ls_on),
  .pwm_s(pwm_s), .en_s(en_s)
);

// File: tb/tb_buck_deadtime_ctrl.sv
module tb_buck_deadtime_ctrl;
  localparam int T_FIX  = 12;
  localparam int T_TMO  = 24;
  localparam int T_HOLD = 4;

  logic clk = 1'b0;
  logic rst_n, pwm_cmd, drv_en, sw_low, lgate_low;
  logic hs_on, ls_on;

  int checks = 0;
  int fails  = 0;
  int sw_mode = 0;   // 0 normal, 1 node never rises, 2 node never falls
  int sw_dly  = 3;
  int gl_dly  = 2;
  int sw_k = 0, gl_k = 0;

  int    exp_kind[$];
  int    exp_gap[$];
  string exp_req[$];

  always #10 clk = ~clk;

  buck_deadtime_ctrl #(.T_FIX(T_FIX), .T_TMO(T_TMO), .T_HOLD(T_HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .drv_en(drv_en),
    .sw_low(sw_low), .lgate_low(lgate_low), .hs_on(hs_on), .ls_on(ls_on)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver side of the scoreboard: kind 1 = upper rise, 0 = lower rise
  task automatic expect_rise(int kind, int gap, string req);
    exp_kind.push_back(kind);
    exp_gap.push_back(gap);
    exp_req.push_back(req);
  endtask

  // power-stage models for the comparator flags
  always @(negedge clk) begin
    if (ls_on) begin
      lgate_low = 1'b0; gl_k = 0;
    end else if (gl_k >= gl_dly) lgate_low = 1'b1;
    else gl_k++;
    case (sw_mode)
      1: sw_low = 1'b1;
      2: if (hs_on) sw_low = 1'b0;
      default: begin
        if (hs_on) begin
          sw_low = 1'b0; sw_k = 0;
        end else if (sw_k >= sw_dly) sw_low = 1'b1;
        else sw_k++;
      end
    endcase
  end

  // monitor: measures the both-off gap preceding each output rise
  logic p_hs = 1'b0, p_ls = 1'b0;
  int gap = 0;
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk(!(hs_on && ls_on), "R3", "both gates high", 1, 0);
      if ((p_hs && !hs_on) || (p_ls && !ls_on)) gap = 1;
      else if (!hs_on && !ls_on) gap++;
      if ((hs_on && !p_hs) || (ls_on && !p_ls)) begin
        if (exp_gap.size() > 0) begin
          int k, g;
          string r;
          k = exp_kind.pop_front();
          g = exp_gap.pop_front();
          r = exp_req.pop_front();
          chk(k == (hs_on ? 1 : 0), r, "rising output (1=upper)", hs_on ? 1 : 0, k);
          chk(gap == g, r, "dead-time cycles", gap, g);
        end
      end
      p_hs = hs_on;
      p_ls = ls_on;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pwm_cmd = 1'b0; drv_en = 1'b0;
    sw_low = 1'b1; lgate_low = 1'b1;
    tick(5);
    chk(!hs_on && !ls_on, "R9", "outputs in reset", {hs_on, ls_on}, 0);
    rst_n = 1'b1;
    tick(8);
    chk(!hs_on && !ls_on, "R2", "outputs while disabled", {hs_on, ls_on}, 0);

    drv_en = 1'b1;
    tick(40);
    chk(ls_on && !hs_on, "R1", "pwm low gives lower on", {hs_on, ls_on}, 1);

    // lower -> upper with gate-sense lag of 2 cycles; input latency
    expect_rise(1, gl_dly + 3 + T_HOLD, "R7");
    pwm_cmd = 1'b1;
    tick(2);
    chk(ls_on, "R9", "lower still on two edges after pwm rise", ls_on, 1);
    tick(1);
    chk(!ls_on, "R9", "lower off on third edge", ls_on, 0);
    tick(40);
    chk(hs_on && !ls_on, "R1", "pwm high gives upper on", {hs_on, ls_on}, 2);

    // upper -> lower, node falls 3 cycles after upper off
    expect_rise(0, sw_dly + 3, "R4");
    pwm_cmd = 1'b0;
    tick(40);
    chk(ls_on && !hs_on, "R1", "lower on after node fall", {hs_on, ls_on}, 1);

    // node never rises: fixed delay
    sw_mode = 1;
    expect_rise(1, gl_dly + 3 + T_HOLD, "R7");
    pwm_cmd = 1'b1;
    tick(40);
    expect_rise(0, T_FIX, "R5");
    pwm_cmd = 1'b0;
    tick(40);

    // node never falls: timeout
    sw_mode = 2;
    expect_rise(1, gl_dly + 3 + T_HOLD, "R7");
    pwm_cmd = 1'b1;
    tick(40);
    expect_rise(0, T_TMO, "R6");
    pwm_cmd = 1'b0;
    tick(50);
    chk(ls_on, "R6", "lower on after timeout", ls_on, 1);
    sw_mode = 0;
    gl_dly = 6;

    // slower gate discharge
    expect_rise(1, gl_dly + 3 + T_HOLD, "R7");
    pwm_cmd = 1'b1;
    tick(40);
    gl_dly = 2;

    // reversal while lower turn-on pending
    sw_mode = 2;
    expect_rise(1, 1 + 4 + T_HOLD, "R8");
    pwm_cmd = 1'b0;
    do @(negedge clk); while (hs_on);
    tick(1);
    pwm_cmd = 1'b1;
    tick(40);
    chk(hs_on && !ls_on, "R8", "upper back on, lower skipped", {hs_on, ls_on}, 2);
    sw_mode = 0;

    // disable while upper on
    drv_en = 1'b0;
    tick(3);
    chk(!hs_on && !ls_on, "R2", "outputs off after disable", {hs_on, ls_on}, 0);
    pwm_cmd = 1'b0;
    tick(20);
    chk(!hs_on && !ls_on, "R2", "off with pwm low", {hs_on, ls_on}, 0);
    pwm_cmd = 1'b1;
    tick(20);
    chk(!hs_on && !ls_on, "R2", "off with pwm high", {hs_on, ls_on}, 0);

    drv_en = 1'b1;
    tick(40);
    chk(hs_on && !ls_on, "R1", "upper on after enable", {hs_on, ls_on}, 2);
    expect_rise(0, sw_dly + 3, "R4");
    pwm_cmd = 1'b0;
    tick(40);
    chk(ls_on && !hs_on, "R1", "lower on at end", {hs_on, ls_on}, 1);

    chk(exp_gap.size() == 0, "R4", "unconsumed expected events", exp_gap.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule